// File: doc/BRIEF.md
# I2C Quasi-Bidirectional Port Expander

This block is an I2C target that controls eight general-purpose lines with no direction register. Each line has one latch bit. A latch bit of 1 leaves the line to a weak pull-up, so the line can be used as an input. A latch bit of 0 pulls the line low. The level seen on each line is the latch bit ANDed with the synchronised external level, so a line reads low when this block or an outside circuit holds it low.

A controller writes one or more bytes to load the latch. It reads bytes to sample the effective port state. An active-low, open-drain interrupt request is raised when the effective state drifts away from the value returned by the most recent read. Reading the port releases the request. A write re-evaluates the request against that last-read value. Eight level outputs follow the effective level of each line, but they are refreshed only by writes, and only for bits whose effective level changed.

The block samples SCL, SDA and the eight line inputs through two-flop synchronisers on a fast system clock. It drives SDA and the interrupt only as pull-down enables.

Top module: `qbport_expander`

## Requirements
- R1: The target address is `{ADDR_HI, addr_pins}`, which is 7 bits wide, followed by a read/write bit where 1 means read. A matching address is acknowledged by pulling SDA low in the ninth clock. Any other address gets no acknowledge, and the transfer has no effect on any output.
- R2: Each data byte of a write is acknowledged and loaded into the latch. `pin_drive_low` equals the bitwise inverse of the latch, so a 0 bit pulls its line low. After a multi-byte write the latch holds the last byte.
- R3: A read returns, MSB first, the effective level: latch AND the synchronised `pin_in`.
- R4: After reset the latch, the sampled inputs and the last-read snapshot are all 0xFF. `pin_level` is 0xFF, and `pin_drive_low`, `int_oe` and `sda_oe` are 0. A read issued right after reset returns 0xFF.
- R5: The data byte is captured into the snapshot when the address is acknowledged. It stays unchanged for the whole byte, even if lines change. The capture releases `int_oe` to 0.
- R6: When the effective level differs from the snapshot and no read or write is taking effect, `int_oe` becomes 1. It stays at 1 until a read or a write, even if the lines return to the snapshot value.
- R7: A write sets `int_oe` to 1 if the new effective level differs from the snapshot, and clears it to 0 otherwise.
- R8: `pin_level` changes only when a write byte is loaded. At that moment each bit whose effective level differs before and after the load takes the new effective level. All other bits keep their value.
- R9: If the controller acknowledges a read byte, the block captures the current effective level again and sends it as the next byte. A not-acknowledge ends the read.
- R10: SDA is driven only through `sda_oe`, where 1 means pull low. `sda_oe` is 0 after a STOP and while any other target is addressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock level seen on the bus |
| sda_i | input | 1 | I2C data level seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_pins | input | 3 | Low three bits of the target address |
| pin_in | input | 8 | External level of each port line |
| pin_drive_low | output | 8 | 1 pulls the corresponding line low |
| pin_level | output | 8 | Per-line level output, refreshed on writes |
| int_oe | output | 1 | 1 pulls the interrupt line low (request active) |

## Verification
A corrupted latch shows up on `pin_drive_low` and in the next read byte, within the same transfer. A stale or wrong snapshot shows up in two ways. The interrupt asserts or clears three system clocks after a line change, when it should not. The byte read back also differs from the AND of the last written value and the line inputs. A mis-stepped target state machine shows up as a missing or misplaced acknowledge in the ninth SCL pulse, or as a bit slip in read data within one byte. Multi-byte reads, mid-transfer line changes and sticky interrupt behaviour are driven directly, so that snapshot timing errors show up as wrong bytes rather than hiding behind single-byte traffic.

// File: rtl/qbx_pkg.sv
package qbx_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WR,
    ST_WACK,
    ST_RD,
    ST_RACK
  } tgt_state_e;
endpackage

// File: rtl/qbx_sync.sv
module qbx_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/qbx_i2c_target.sv
module qbx_i2c_target
  import qbx_pkg::*;
#(
  parameter logic [3:0] ADDR_HI = 4'b0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic [2:0]        strap,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              sda_oe,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_cap
);
  localparam logic [6:0] ADDR_BASE = {ADDR_HI, 3'b000};

  tgt_state_e        state_q, state_n;
  logic              scl_d, sda_d;
  logic [3:0]        cnt_q, cnt_n;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic              rw_q, rw_n, ack_q, ack_n;
  logic              oe_q, oe_n, wr_q, wr_n, cap_q, cap_n;
  logic              scl_rise, scl_fall, start_ev, stop_ev;
  logic [6:0]        my_addr;

  assign my_addr  = ADDR_BASE | {4'b0000, strap};
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    rw_n    = rw_q;
    ack_n   = ack_q;
    oe_n    = oe_q;
    wr_n    = 1'b0;
    cap_n   = 1'b0;
    if (stop_ev) begin
      state_n = ST_IDLE;
      oe_n    = 1'b0;
    end else if (start_ev) begin
      state_n = ST_ADDR;
      cnt_n   = 4'd0;
      oe_n    = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_WR: begin
          if (scl_rise) begin
            sh_n  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_n = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            if (state_q == ST_WR) begin
              wr_n    = 1'b1;
              oe_n    = 1'b1;
              state_n = ST_WACK;
            end else if (sh_q[7:1] == my_addr) begin
              oe_n    = 1'b1;
              rw_n    = sh_q[0];
              cap_n   = sh_q[0];
              state_n = ST_AACK;
            end else begin
              state_n = ST_IDLE;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            if (rw_q) begin
              state_n = ST_RD;
              oe_n    = ~tx_byte[7];
              cnt_n   = 4'd1;
            end else begin
              state_n = ST_WR;
              oe_n    = 1'b0;
              cnt_n   = 4'd0;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            state_n = ST_WR;
            oe_n    = 1'b0;
            cnt_n   = 4'd0;
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              oe_n    = 1'b0;
              state_n = ST_RACK;
            end else begin
              oe_n  = ~tx_byte[3'd7 - cnt_q[2:0]];
              cnt_n = cnt_q + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            ack_n = ~sda_s;
            cap_n = ~sda_s;
          end else if (scl_fall) begin
            if (ack_q) begin
              state_n = ST_RD;
              oe_n    = ~tx_byte[7];
              cnt_n   = 4'd1;
            end else begin
              state_n = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      scl_d   <= 1'b1;
      sda_d   <= 1'b1;
      cnt_q   <= 4'd0;
      sh_q    <= '0;
      rw_q    <= 1'b0;
      ack_q   <= 1'b0;
      oe_q    <= 1'b0;
      wr_q    <= 1'b0;
      cap_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      scl_d   <= scl_s;
      sda_d   <= sda_s;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      rw_q    <= rw_n;
      ack_q   <= ack_n;
      oe_q    <= oe_n;
      wr_q    <= wr_n;
      cap_q   <= cap_n;
    end
  end

  assign sda_oe  = oe_q;
  assign wr_stb  = wr_q;
  assign wr_data = sh_q;
  assign rd_cap  = cap_q;
endmodule

// File: rtl/qbx_port_core.sv
module qbx_port_core #(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_s,
  input  logic             wr_stb,
  input  logic [LINES-1:0] wr_data,
  input  logic             rd_cap,
  output logic [LINES-1:0] snap,
  output logic [LINES-1:0] drive_low,
  output logic [LINES-1:0] level,
  output logic             int_oe
);
  logic [LINES-1:0] latch_q, latch_n, snap_q, snap_n, lvl_q, lvl_n;
  logic [LINES-1:0] eff, new_eff, chg;
  logic             int_q, int_n;

  assign eff     = latch_q & line_s;
  assign new_eff = wr_data & line_s;
  assign chg     = eff ^ new_eff;

  always_comb begin
    latch_n = latch_q;
    snap_n  = snap_q;
    int_n   = int_q;
    if (rd_cap) begin
      snap_n = eff;
      int_n  = 1'b0;
    end else if (wr_stb) begin
      latch_n = wr_data;
      int_n   = (new_eff != snap_q);
    end else if (eff != snap_q) begin
      int_n = 1'b1;
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_lvl
    assign lvl_n[i] = (wr_stb && chg[i]) ? new_eff[i] : lvl_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '1;
      snap_q  <= '1;
      lvl_q   <= '1;
      int_q   <= 1'b0;
    end else begin
      latch_q <= latch_n;
      snap_q  <= snap_n;
      lvl_q   <= lvl_n;
      int_q   <= int_n;
    end
  end

  assign snap      = snap_q;
  assign drive_low = ~latch_q;
  assign level     = lvl_q;
  assign int_oe    = int_q;
endmodule

// File: rtl/qbport_expander.sv
module qbport_expander
  import qbx_pkg::*;
#(
  parameter logic [3:0] ADDR_HI = 4'b0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        addr_pins,
  input  logic [BYTE_W-1:0] pin_in,
  output logic [BYTE_W-1:0] pin_drive_low,
  output logic [BYTE_W-1:0] pin_level,
  output logic              int_oe
);
  logic [1:0]        rst_ff;
  logic              rst_ns;
  logic [1:0]        bus_s;
  logic [BYTE_W-1:0] line_s, wr_data, snap;
  logic              wr_stb, rd_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_ns = rst_ff[1];

  qbx_sync #(.W(2), .RST_VAL(2'b11)) u_bus_sync (
    .clk(clk), .rst_n(rst_ns), .d({scl_i, sda_i}), .q(bus_s)
  );

  qbx_sync #(.W(BYTE_W), .RST_VAL({BYTE_W{1'b1}})) u_line_sync (
    .clk(clk), .rst_n(rst_ns), .d(pin_in), .q(line_s)
  );

  qbx_i2c_target #(.ADDR_HI(ADDR_HI)) u_target (
    .clk(clk), .rst_n(rst_ns), .scl_s(bus_s[1]), .sda_s(bus_s[0]),
    .strap(addr_pins), .tx_byte(snap), .sda_oe(sda_oe),
    .wr_stb(wr_stb), .wr_data(wr_data), .rd_cap(rd_cap)
  );

  qbx_port_core #(.LINES(BYTE_W)) u_core (
    .clk(clk), .rst_n(rst_ns), .line_s(line_s), .wr_stb(wr_stb),
    .wr_data(wr_data), .rd_cap(rd_cap), .snap(snap),
    .drive_low(pin_drive_low), .level(pin_level), .int_oe(int_oe)
  );
endmodule

// File: rtl/qbx_checker.sv
module qbx_checker #(
  parameter int LINES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_stb,
  input logic             rd_cap,
  input logic [LINES-1:0] wr_data,
  input logic [LINES-1:0] line_s,
  input logic [LINES-1:0] snap,
  input logic [LINES-1:0] pin_drive_low,
  input logic [LINES-1:0] pin_level,
  input logic             int_oe
);
  a_r2_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(pin_drive_low));

  a_r8_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(pin_level));

  a_r5_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_cap |=> $stable(snap));

  a_r5_int_release: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cap |=> !int_oe);

  a_r6_int_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_cap && !wr_stb && ((~pin_drive_low & line_s) != snap)) |=> int_oe);

  a_r6_int_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (int_oe && !rd_cap && !wr_stb) |=> int_oe);

  a_r7_write_eval: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (int_oe == (($past(wr_data) & $past(line_s)) != snap)));

  a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && rd_cap));
endmodule

bind qbport_expander qbx_checker #(.LINES(8)) u_chk (
  .clk(clk), .rst_n(rst_ns), .wr_stb(wr_stb), .rd_cap(rd_cap),
  .wr_data(wr_data), .line_s(line_s), .snap(snap),
  .pin_drive_low(pin_drive_low), .pin_level(pin_level), .int_oe(int_oe)
);

// File: tb/qbport_expander_test.sv
module qbport_expander_test;
  localparam int Q = 8;
  localparam logic [6:0] DEV = {4'b0100, 3'b011};
  localparam logic [15:0] VEC [6] = '{16'hA5FF, 16'hFF3C, 16'h0FF0,
                                      16'h00FF, 16'hFFFF, 16'h817E};

  logic       clk = 1'b0;
  logic       rst_n, scl_m, sda_m, sda_oe, int_oe;
  logic [2:0] strap;
  logic [7:0] pins, drive_low, level;
  logic       sda_bus;
  int         n_chk = 0, n_err = 0, cyc = 0;
  logic [7:0] latch_m, snap_m, level_m;
  logic       int_m;

  assign sda_bus = sda_m & ~sda_oe;
  always #5 clk = ~clk;

  qbport_expander uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_pins(strap), .pin_in(pins), .pin_drive_low(drive_low),
    .pin_level(level), .int_oe(int_oe)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    b = sda_bus; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic tx_byte(input logic [7:0] d, output logic nack);
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(nack);
  endtask

  task automatic rx_byte(input logic nack_out, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(nack_out);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] d,
                          output logic na, output logic nd);
    i2c_start;
    tx_byte({a, 1'b0}, na);
    if (!na) tx_byte(d, nd);
    else nd = 1'b1;
    i2c_stop;
    tick(6);
  endtask

  task automatic do_read(input logic [6:0] a, output logic [7:0] d, output logic na);
    i2c_start;
    tx_byte({a, 1'b1}, na);
    if (!na) rx_byte(1'b1, d);
    else d = 8'h00;
    i2c_stop;
    tick(6);
  endtask

  task automatic model_pins(input logic [7:0] p);
    pins = p;
    tick(6);
    if ((latch_m & p) != snap_m) int_m = 1'b1;
  endtask

  task automatic model_write(input logic [7:0] d);
    logic [7:0] pe, ne, ch;
    pe = latch_m & pins;
    ne = d & pins;
    ch = pe ^ ne;
    level_m = (level_m & ~ch) | (ne & ch);
    latch_m = d;
    int_m = (ne != snap_m);
  endtask

  task automatic model_read;
    snap_m = latch_m & pins;
    int_m = 1'b0;
  endtask

  task automatic write_checked(input string req, input logic [7:0] d);
    logic na, nd;
    do_write(DEV, d, na, nd);
    model_write(d);
    chk({req, " ack"}, {6'd0, na, nd}, 8'h00);
    chk({req, " drive"}, drive_low, ~latch_m);
    chk({req, " level R8"}, level, level_m);
    chk({req, " int R7"}, {7'd0, int_oe}, {7'd0, int_m});
  endtask

  task automatic read_checked(input string req);
    logic [7:0] d;
    logic na;
    do_read(DEV, d, na);
    chk({req, " read R3"}, d, latch_m & pins);
    model_read;
    chk({req, " int R5"}, {7'd0, int_oe}, 8'h00);
  endtask

  initial begin
    logic na, nd, n2;
    logic [7:0] d1, d2;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; strap = 3'b011; pins = 8'hFF;
    latch_m = 8'hFF; snap_m = 8'hFF; level_m = 8'hFF; int_m = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(6);

    // R4 reset state
    chk("R4 sda_oe", {7'd0, sda_oe}, 8'h00);
    chk("R4 int_oe", {7'd0, int_oe}, 8'h00);
    chk("R4 drive", drive_low, 8'h00);
    chk("R4 level", level, 8'hFF);
    do_read(DEV, d1, na);
    chk("R4 R1 ack", {7'd0, na}, 8'h00);
    chk("R4 read", d1, 8'hFF);

    // Vector walk: R2 R3 R7 R8 R5
    for (int k = 0; k < 6; k++) begin
      model_pins(VEC[k][7:0]);
      write_checked("R2 vec", VEC[k][15:8]);
      read_checked("vec");
    end

    // R1 foreign address ignored, strap selects address, R10 release
    model_pins(8'hFF);
    write_checked("R2 prep", 8'h3C);
    read_checked("prep");
    do_write(DEV ^ 7'h01, 8'h00, na, nd);
    chk("R1 foreign nack", {7'd0, na}, 8'h01);
    chk("R1 foreign no effect", drive_low, ~latch_m);
    chk("R10 sda released", {7'd0, sda_oe}, 8'h00);
    strap = 3'b101;
    tick(4);
    do_write({4'b0100, 3'b101}, 8'hC3, na, nd);
    model_write(8'hC3);
    chk("R1 strap ack", {6'd0, na, nd}, 8'h00);
    chk("R1 strap drive", drive_low, 8'h3C);
    do_write(DEV, 8'h00, na, nd);
    chk("R1 old addr nack", {7'd0, na}, 8'h01);
    strap = 3'b011;
    tick(4);

    // R6 / R7 interrupt behaviour
    write_checked("R7 set", 8'hFF);
    read_checked("R6 base");
    model_pins(8'hF7);
    chk("R6 int on change", {7'd0, int_oe}, 8'h01);
    model_pins(8'hFF);
    chk("R6 int sticky", {7'd0, int_oe}, 8'h01);
    write_checked("R7 equal", 8'hFF);
    chk("R7 cleared", {7'd0, int_oe}, 8'h00);
    write_checked("R7 differ", 8'hFE);
    chk("R7 raised", {7'd0, int_oe}, 8'h01);
    read_checked("R7 clear");

    // R8 level follows only changed bits on writes
    write_checked("R8 a", 8'hFF);
    model_pins(8'hFE);
    chk("R8 no write", level, level_m);
    write_checked("R8 b", 8'hFE);
    write_checked("R8 c", 8'h7E);
    chk("R8 explicit", level, 8'h7F);
    model_pins(8'hFF);
    read_checked("R8 done");

    // R5 / R9 multi-byte read with a line change after capture
    write_checked("R9 prep", 8'hF0);
    read_checked("R9 base");
    i2c_start;
    tx_byte({DEV, 1'b1}, na);
    chk("R9 ack", {7'd0, na}, 8'h00);
    pins = 8'h3F;
    tick(8);
    rx_byte(1'b0, d1);
    chk("R5 stable byte", d1, 8'hF0);
    rx_byte(1'b1, d2);
    chk("R9 second byte", d2, 8'h30);
    i2c_stop;
    tick(6);
    model_read;
    chk("R5 int after read", {7'd0, int_oe}, 8'h00);
    chk("R10 after nack", {7'd0, sda_oe}, 8'h00);
    model_pins(8'hFF);

    // R2 multi-byte write
    i2c_start;
    tx_byte({DEV, 1'b0}, na);
    tx_byte(8'h55, nd);
    tx_byte(8'hAA, n2);
    i2c_stop;
    tick(6);
    model_write(8'h55);
    model_write(8'hAA);
    chk("R2 multi ack", {5'd0, na, nd, n2}, 8'h00);
    chk("R2 multi last", drive_low, 8'h55);
    chk("R8 multi level", level, level_m);
    read_checked("R2 final");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule